// File: doc/BRIEF.md
# Debug Breakpoint Address Matcher

The block holds four watch slots, each made of an address register and a kind/length field in a shared control word, and compares every presented event against all four. An event carries the address of the instruction now retiring and, optionally, one data access (address, size, read or write). Slots of the instruction kind compare against the instruction address. Slots of the data kinds compare the accessed byte range against an aligned watch window. Slots of the port kind never match.

Each evaluation builds a new low nibble of the status word, with one bit per matching slot, including slots whose enables are off. The nibble is committed only when an enabled slot matched or the event asks for a forced update. A one-cycle trap pulse follows an event in which an enabled slot matched. Software loads the four addresses, the control word and the status word through a plain write port.

Events enter through a valid/ready handshake. A register write has priority: in any cycle with `cfg_we` high, `evt_ready` is low, and an event held valid in that cycle is not taken and leaves no trace. When `cfg_we` is low, `evt_ready` is high and an event is accepted on the same edge.

Top module: `dbg_bp_matcher`

## Requirements
- R1: After reset the status word is 0, the trap output is 0, and all four watch addresses and the control word are 0.
- R2: A write with `cfg_sel` 0 to 3 loads that slot's address, 4 loads the control word, and 5 loads the status word, which appears on `dbg_status` after the next edge. Selectors 6 and 7 change nothing.
- R3: A slot whose kind field is 00 matches when its address equals `evt_ip`. Its length field has no effect.
- R4: A slot of kind 01 matches only when `evt_dvalid` and `evt_dwrite` are both high and the ranges overlap.
- R5: A slot of kind 11 matches any data access (`evt_dvalid` high, read or write) whose range overlaps.
- R6: A slot of kind 10 never matches.
- R7: Control bits [16+4i+1:16+4i] give slot i's kind and bits [18+4i+1:18+4i] give its length code: 00 is 1 byte, 01 is 2 bytes, 11 is 4 bytes and 10 is 8 bytes. The watch window is the slot address rounded down to a multiple of that length. `evt_dsize` codes 0 to 3 give a 1, 2, 4 or 8 byte access starting at `evt_daddr`. A data match needs at least one byte shared between the access and the window.
- R8: On a commit, status bits [3:0] are replaced by the set of matching slots, bit i for slot i, whether or not that slot is enabled. Status bits [31:4] keep their value.
- R9: An accepted event changes the status word only when an enabled slot matched or `evt_force` is high. Otherwise the status word holds.
- R10: `dbg_trap` is high for exactly the one cycle after an accepted event in which an enabled slot matched. A forced update alone gives no trap.
- R11: `evt_ready` is low exactly when `cfg_we` is high. An event that is not accepted changes neither the status word nor the trap output.
- R12: Slot i is enabled when control bit 2i or bit 2i+1 is set. Either bit alone is enough.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register selector (0-3 address, 4 control, 5 status) |
| cfg_wdata | input | 32 | Register write data |
| evt_valid | input | 1 | Event presented |
| evt_ready | output | 1 | Event accepted this cycle when high together with evt_valid |
| evt_ip | input | 32 | Address of the retiring instruction |
| evt_dvalid | input | 1 | Event carries a data access |
| evt_daddr | input | 32 | First byte of the data access |
| evt_dsize | input | 2 | Access size code (0:1, 1:2, 2:4, 3:8 bytes) |
| evt_dwrite | input | 1 | Data access is a write |
| evt_force | input | 1 | Commit the hit nibble even without an enabled match |
| dbg_status | output | 32 | Status word; bits [3:0] are the last committed hit set |
| dbg_trap | output | 1 | Debug trap pulse |

## Verification
A wrong address, kind or length held in a slot goes unseen until an event lands near that slot. It then shows up in the next cycle, either as a wrong bit in the status nibble or as a trap that is missing or extra. A bad enable decode is harder to see: it shows only as a missed or spurious commit, so events that hit disabled slots are followed by a forced update to bring the raw hit set out to the ports. The bench model predicts status, trap and ready on every cycle. It runs directed corner cases first, then random traffic centred on the programmed addresses.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;

  typedef enum logic [1:0] {
    KIND_EXEC   = 2'b00,
    KIND_WRITE  = 2'b01,
    KIND_PORT   = 2'b10,
    KIND_ACCESS = 2'b11
  } watch_kind_e;

  localparam logic [2:0] SEL_CTRL = 3'd4;
  localparam logic [2:0] SEL_STAT = 3'd5;

  localparam int KIND_LSB = 16;
  localparam int LEN_LSB  = 18;
  localparam int FLD_STEP = 4;

  // length code to byte count of the watch window
  function automatic logic [3:0] span_bytes(input logic [1:0] code);
    case (code)
      2'b00:   span_bytes = 4'd1;
      2'b01:   span_bytes = 4'd2;
      2'b11:   span_bytes = 4'd4;
      default: span_bytes = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/dbgm_slot.sv
module dbgm_slot
  import dbgm_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] watch_addr,
  input  watch_kind_e   kind,
  input  logic [1:0]    len_code,
  input  logic [AW-1:0] ip,
  input  logic          dvalid,
  input  logic [AW-1:0] daddr,
  input  logic [3:0]    dbytes,
  input  logic          dwrite,
  output logic          hit
);

  localparam int XW = AW + 1;

  logic [3:0]    span;
  logic [XW-1:0] win_mask;
  logic [XW-1:0] win_lo, win_hi, acc_lo, acc_hi;
  logic          overlap;

  assign span     = span_bytes(len_code);
  assign win_mask = ~(XW'(span) - XW'(1));
  assign win_lo   = {1'b0, watch_addr} & win_mask;
  assign win_hi   = win_lo + XW'(span) - XW'(1);
  assign acc_lo   = {1'b0, daddr};
  assign acc_hi   = acc_lo + XW'(dbytes) - XW'(1);
  // extra top bit keeps the range ends from wrapping
  assign overlap  = (acc_lo <= win_hi) && (win_lo <= acc_hi);

  always_comb begin
    case (kind)
      KIND_EXEC:   hit = (watch_addr == ip);
      KIND_WRITE:  hit = dvalid && dwrite && overlap;
      KIND_ACCESS: hit = dvalid && overlap;
      default:     hit = 1'b0;
    endcase
  end

  assert_port_never_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == KIND_PORT) |-> !hit)
    else $error("port-kind slot reported a hit");

  assert_exec_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && kind == KIND_EXEC) |-> (watch_addr == ip))
    else $error("instruction slot hit on a different address");

  assert_write_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && kind == KIND_WRITE) |-> (dvalid && dwrite))
    else $error("write slot hit without a write access");

endmodule

// File: rtl/dbgm_status.sv
module dbgm_status #(
  parameter int DW    = 32,
  parameter int NSLOT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_we,
  input  logic [DW-1:0]    st_wdata,
  input  logic             fire,
  input  logic             force_upd,
  input  logic [NSLOT-1:0] hit,
  input  logic [NSLOT-1:0] en,
  output logic [DW-1:0]    status,
  output logic             trap
);

  logic any_en;
  assign any_en = |(hit & en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      trap   <= 1'b0;
    end else begin
      trap <= fire && any_en;
      if (st_we)
        status <= st_wdata;
      else if (fire && (any_en || force_upd))
        status <= {status[DW-1:NSLOT], hit};
    end
  end

  assert_trap_after_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> $past(fire))
    else $error("trap without an accepted event");

  assert_trap_has_hits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (status[NSLOT-1:0] != '0))
    else $error("trap with an empty hit nibble");

  assert_quiet_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_we && !(fire && (force_upd || any_en))) |=> $stable(status))
    else $error("status changed without a commit or write");

endmodule

// File: rtl/dbg_bp_matcher.sv
module dbg_bp_matcher
  import dbgm_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int NSLOT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          evt_valid,
  output logic          evt_ready,
  input  logic [AW-1:0] evt_ip,
  input  logic          evt_dvalid,
  input  logic [AW-1:0] evt_daddr,
  input  logic [1:0]    evt_dsize,
  input  logic          evt_dwrite,
  input  logic          evt_force,
  output logic [DW-1:0] dbg_status,
  output logic          dbg_trap
);

  localparam int ENW  = 2 * NSLOT;
  localparam int FLDW = FLD_STEP * NSLOT;

  logic [AW-1:0]    waddr [NSLOT];
  logic [ENW-1:0]   en_bits;
  logic [FLDW-1:0]  fld_bits;
  logic [NSLOT-1:0] hit, en;
  logic [3:0]       dbytes;
  logic             fire;

  assign evt_ready = !cfg_we;
  assign fire      = evt_valid && evt_ready;
  assign dbytes    = 4'd1 << evt_dsize;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_bits  <= '0;
      fld_bits <= '0;
    end else if (cfg_we && cfg_sel == SEL_CTRL) begin
      en_bits  <= cfg_wdata[ENW-1:0];
      fld_bits <= cfg_wdata[KIND_LSB +: FLDW];
    end
  end

  for (genvar gi = 0; gi < NSLOT; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        waddr[gi] <= '0;
      else if (cfg_we && cfg_sel == 3'(gi))
        waddr[gi] <= AW'(cfg_wdata);
    end

    assign en[gi] = en_bits[2*gi] | en_bits[2*gi+1];

    dbgm_slot #(.AW(AW)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .watch_addr (waddr[gi]),
      .kind       (watch_kind_e'(fld_bits[FLD_STEP*gi +: 2])),
      .len_code   (fld_bits[FLD_STEP*gi + (LEN_LSB - KIND_LSB) +: 2]),
      .ip         (evt_ip),
      .dvalid     (evt_dvalid),
      .daddr      (evt_daddr),
      .dbytes     (dbytes),
      .dwrite     (evt_dwrite),
      .hit        (hit[gi])
    );
  end

  dbgm_status #(.DW(DW), .NSLOT(NSLOT)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_we     (cfg_we && cfg_sel == SEL_STAT),
    .st_wdata  (cfg_wdata),
    .fire      (fire),
    .force_upd (evt_force),
    .hit       (hit),
    .en        (en),
    .status    (dbg_status),
    .trap      (dbg_trap)
  );

  assert_stall_no_trap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && cfg_we && cfg_sel != SEL_STAT) |=> (!dbg_trap && $stable(dbg_status)))
    else $error("stalled event left a trace");

endmodule

// File: tb/tb_dbg_bp_matcher.sv
module tb_dbg_bp_matcher;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic        evt_valid = 0;
  logic        evt_ready;
  logic [31:0] evt_ip = 0;
  logic        evt_dvalid = 0;
  logic [31:0] evt_daddr = 0;
  logic [1:0]  evt_dsize = 0;
  logic        evt_dwrite = 0;
  logic        evt_force = 0;
  logic [31:0] dbg_status;
  logic        dbg_trap;

  int runs = 0;
  int fails = 0;
  string cur_req = "R1";
  bit started = 0;

  longint      m_addr [4];
  logic [31:0] m_ctrl, m_stat;
  logic        m_trap;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_bp_matcher dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_ip(evt_ip), .evt_dvalid(evt_dvalid),
    .evt_daddr(evt_daddr), .evt_dsize(evt_dsize), .evt_dwrite(evt_dwrite),
    .evt_force(evt_force), .dbg_status(dbg_status), .dbg_trap(dbg_trap)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural match: walk every accessed byte and test its window
  function automatic bit m_match(int i);
    logic [1:0] k;
    logic [1:0] lc;
    longint span, base, nb, x;
    bit ovl;
    k = m_ctrl[16+4*i +: 2];
    lc = m_ctrl[18+4*i +: 2];
    case (lc)
      2'b00: span = 1;
      2'b01: span = 2;
      2'b11: span = 4;
      default: span = 8;
    endcase
    base = m_addr[i] - (m_addr[i] % span);
    nb = longint'(1) << evt_dsize;
    ovl = 0;
    for (longint b = 0; b < nb; b++) begin
      x = longint'(evt_daddr) + b;
      if (x - (x % span) == base) ovl = 1;
    end
    case (k)
      2'b00: return m_addr[i] == longint'(evt_ip);
      2'b01: return evt_dvalid && evt_dwrite && ovl;
      2'b10: return 0;
      default: return evt_dvalid && ovl;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_addr[i] = 0;
      m_ctrl = 0; m_stat = 0; m_trap = 0;
    end else if (cfg_we) begin
      m_trap = 0;
      if (cfg_sel < 4) m_addr[cfg_sel] = longint'(cfg_wdata);
      else if (cfg_sel == 4) m_ctrl = cfg_wdata;
      else if (cfg_sel == 5) m_stat = cfg_wdata;
    end else if (evt_valid) begin
      logic [3:0] h;
      bit anyen;
      anyen = 0;
      for (int i = 0; i < 4; i++) begin
        h[i] = m_match(i);
        if (h[i] && (m_ctrl[2*i] || m_ctrl[2*i+1])) anyen = 1;
      end
      m_trap = anyen;
      if (anyen || evt_force) m_stat[3:0] = h;
    end else begin
      m_trap = 0;
    end
  end

  // cycle compare, away from the edge; inputs move 2 time units after negedge
  always @(negedge clk) begin
    if (started && rst_n) begin
      chk(cur_req, "status vs model", longint'(dbg_status), longint'(m_stat));
      chk(cur_req, "trap vs model", longint'(dbg_trap), longint'(m_trap));
      chk("R11", "ready vs write strobe", longint'(evt_ready), longint'(!cfg_we));
    end
  end

  task automatic wreg(logic [2:0] sel, logic [31:0] data);
    @(negedge clk); #2;
    cfg_we = 1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk); #2;
    cfg_we = 0;
  endtask

  task automatic evt(logic [31:0] ip, logic dv, logic [31:0] da, logic [1:0] ds,
                     logic dw, logic frc);
    @(negedge clk); #2;
    evt_valid = 1; evt_ip = ip; evt_dvalid = dv; evt_daddr = da;
    evt_dsize = ds; evt_dwrite = dw; evt_force = frc;
    @(negedge clk); #2;
    evt_valid = 0; evt_force = 0; evt_dvalid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2 rst_n = 1;
    started = 1;
    @(negedge clk); #1;
    cur_req = "R1";
    chk("R1", "reset status", longint'(dbg_status), 0);
    chk("R1", "reset trap", longint'(dbg_trap), 0);
    // R1: zero addresses and control mean slot 0 is an enabled-off exec slot at 0
    evt(32'h0, 0, 0, 0, 0, 1);
    chk("R1", "reset slots hit at ip 0", longint'(dbg_status[3:0]), 4'hF);

    cur_req = "R2";
    wreg(0, 32'h1000); wreg(1, 32'h2004); wreg(2, 32'h3000); wreg(3, 32'h4000);
    wreg(4, 32'h2BD0_0049);

    cur_req = "R3";
    evt(32'h1000, 0, 0, 0, 0, 0);
    chk("R3", "exec hit nibble", longint'(dbg_status[3:0]), 1);
    chk("R10", "exec trap", longint'(dbg_trap), 1);

    cur_req = "R4";
    evt(32'h500, 1, 32'h2006, 0, 1, 0);
    chk("R4", "write hit nibble", longint'(dbg_status[3:0]), 2);
    chk("R12", "G bit enables trap", longint'(dbg_trap), 1);
    evt(32'h500, 1, 32'h2006, 0, 0, 0);
    chk("R4", "read ignored by write slot", longint'(dbg_status[3:0]), 2);
    chk("R4", "no trap on read", longint'(dbg_trap), 0);

    cur_req = "R9";
    evt(32'h500, 1, 32'h3007, 1, 0, 0);
    chk("R9", "disabled hit not committed", longint'(dbg_status[3:0]), 2);
    chk("R9", "disabled hit no trap", longint'(dbg_trap), 0);
    evt(32'h500, 1, 32'h3007, 1, 0, 1);
    chk("R8", "forced commit shows disabled hit", longint'(dbg_status[3:0]), 4);
    chk("R10", "force alone gives no trap", longint'(dbg_trap), 0);

    cur_req = "R6";
    evt(32'h500, 1, 32'h4000, 2, 1, 1);
    chk("R6", "port slot never hits", longint'(dbg_status[3:0]), 0);

    cur_req = "R8";
    wreg(5, 32'hABCD_0000);
    chk("R2", "status write", longint'(dbg_status), 32'hABCD_0000);
    evt(32'h1000, 1, 32'h3006, 2, 1, 0);
    chk("R8", "multi hit keeps upper bits", longint'(dbg_status), 32'hABCD_0005);
    chk("R5", "rw slot hit on write", longint'(dbg_status[2]), 1);

    cur_req = "R7";
    evt(32'h500, 1, 32'h2003, 0, 1, 1);
    chk("R7", "byte below window misses", longint'(dbg_status[3:0]), 0);
    evt(32'h500, 1, 32'h2002, 2, 1, 0);
    chk("R7", "straddling write hits", longint'(dbg_status[3:0]), 2);
    wreg(1, 32'h2006);
    evt(32'h500, 1, 32'h2004, 0, 1, 0);
    chk("R7", "window aligned down", longint'(dbg_status[3:0]), 2);
    wreg(4, 32'h2BD0_0059);
    evt(32'h500, 1, 32'h2FFC, 3, 0, 0);
    chk("R7", "8-byte read hits 8-byte window", longint'(dbg_status[3:0]), 4);
    chk("R5", "rw slot trap on read", longint'(dbg_trap), 1);
    evt(32'h500, 1, 32'h2FF8, 2, 0, 1);
    chk("R7", "adjacent range misses", longint'(dbg_status[3:0]), 0);

    cur_req = "R11";
    @(negedge clk); #2;
    cfg_we = 1; cfg_sel = 6; cfg_wdata = 32'hFFFF_FFFF;
    evt_valid = 1; evt_ip = 32'h1000; evt_dvalid = 0;
    #1 chk("R11", "ready low during write", longint'(evt_ready), 0);
    @(negedge clk); #1;
    chk("R11", "stalled event no trap", longint'(dbg_trap), 0);
    chk("R2", "selector 6 ignored", longint'(dbg_status), 32'hABCD_0000);
    #1 cfg_we = 0; evt_valid = 0;
    evt(32'h1000, 0, 0, 0, 0, 0);
    chk("R2", "slot 0 unchanged by selector 6", longint'(dbg_status[3:0]), 1);

    cur_req = "R3/R4/R5 random";
    for (int n = 0; n < 600; n++) begin
      int k;
      @(negedge clk); #2;
      k = $urandom_range(0, 3);
      cfg_we = ($urandom_range(0, 9) == 0);
      cfg_sel = 3'($urandom_range(0, 7));
      cfg_wdata = (cfg_sel < 4) ? 32'h1000 * ($urandom_range(1, 4)) + $urandom_range(0, 15)
                                : $urandom;
      evt_valid = ($urandom_range(0, 3) != 0);
      evt_ip = ($urandom_range(0, 1) == 0) ? 32'(m_addr[k]) : 32'($urandom_range(0, 32'h5000));
      evt_dvalid = $urandom_range(0, 1);
      evt_daddr = 32'(m_addr[k] + longint'($urandom_range(0, 16)) - 8);
      evt_dsize = 2'($urandom_range(0, 3));
      evt_dwrite = $urandom_range(0, 1);
      evt_force = ($urandom_range(0, 4) == 0);
    end
    @(negedge clk); #2;
    cfg_we = 0; evt_valid = 0;
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

endmodule